// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Controller

This block handles the device-side response to the active-low hardware reset pin of a flash-style memory model. It samples the pin on the model clock and qualifies a reset only when the pin has stayed low for a minimum number of clock edges. On a qualified reset it sends a one-cycle abort pulse to the embedded program/erase engine and holds the command state machine in its array-read state. It closes the data output gate and the command path, then releases them only when two conditions hold: the internal ready time has expired, and the pin has been high for a recovery interval.

The internal ready time depends on what the engine was doing when the reset was qualified. If the engine was busy, a long ready time applies and the ready/busy output is held low until it expires. If the engine was idle, a short ready time applies and ready/busy stays high. A low pulse shorter than the minimum still gates the outputs while the pin is low, but it aborts nothing and changes no state. All four times are parameters counted in clock cycles.

Top module: `flash_rst_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, with the pin high and `busy_i` low: `rdy_o`, `oe_en_o` and `cmd_en_o` are 1, and `abort_o` and `sm_rst_o` are 0.
- R2: In every cycle in which `dev_rst_ni` is 0, `oe_en_o` and `cmd_en_o` are 0.
- R3: If the pin is low at fewer than MIN_PULSE consecutive rising edges, the pulse is ignored. `abort_o` and `sm_rst_o` stay 0, `rdy_o` equals the inverse of `busy_i`, and `oe_en_o` and `cmd_en_o` return to 1 as soon as the pin is high.
- R4: When the pin is low at MIN_PULSE consecutive rising edges, `abort_o` is 1 for exactly the one cycle that follows the MIN_PULSE-th of those edges.
- R5: `sm_rst_o`, which holds the command state machine in array-read mode, is 1 from the qualifying edge until the reset completes.
- R6: If `busy_i` was 1 at the qualifying edge, `rdy_o` is 0 from that edge until RDY_BUSY further edges have passed.
- R7: If `busy_i` was 0 at the qualifying edge, `rdy_o` stays 1 throughout the reset, and the ready time is RDY_IDLE edges.
- R8: The reset completes after the later of two edges: the qualifying edge plus the ready time, and the last low edge plus RECOVER. Before that, `oe_en_o` and `cmd_en_o` are 0. From that cycle on, `oe_en_o` and `cmd_en_o` are 1 and `sm_rst_o` is 0.
- R9: A new low on the pin during recovery restarts the recovery count and does not issue a second abort.
- R10: During a reset, `rdy_o` does not follow `busy_i`. After completion it again equals the inverse of `busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| dev_rst_ni | input | 1 | Device hardware reset pin, active low, synchronous to clk_i |
| busy_i | input | 1 | Embedded program/erase engine is running |
| rdy_o | output | 1 | Ready/busy indication, 1 = ready |
| oe_en_o | output | 1 | Data bus output enable gate |
| abort_o | output | 1 | One-cycle abort pulse to the engine |
| cmd_en_o | output | 1 | Command writes are accepted |
| sm_rst_o | output | 1 | Forces the command state machine to array-read mode |

## Verification
The hardest case to reach is a pin that drops a second time while recovery is still counting. Here the recovery timer must restart while the ready timer keeps running, and no second abort may appear. A directed pin pattern produces this case: a qualifying low, two high cycles, one more low, then high. A sweep over low-pulse lengths, running from below the minimum to past the busy ready time, makes each of the two timers the one that decides completion. The sweep runs with the engine both busy and idle, and it flips `busy_i` right after qualification to show that the busy input is ignored during reset.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    PH_RUN = 2'd0,
    PH_LOW = 2'd1,
    PH_RST = 2'd2
  } phase_e;
endpackage

// File: rtl/frc_pulse_qual.sv
module frc_pulse_qual #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic hold_i,
  output logic hit_o,
  output logic abort_o
);
  localparam int W = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE + 1);

  logic [W-1:0] low_cnt_q;
  logic         abort_q;

  assign hit_o   = !pin_ni && !hold_i && (low_cnt_q == W'(MIN_PULSE - 1));
  assign abort_o = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      abort_q   <= 1'b0;
    end else begin
      abort_q <= hit_o;
      if (pin_ni || hold_i || hit_o) low_cnt_q <= '0;
      else                           low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assert_abort_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  assert_abort_after_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(!pin_ni));
endmodule

// File: rtl/frc_sat_timer.sv
module frc_sat_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (en_i && cnt_q < limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_done_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> (done_o || !$stable(limit_i)));
endmodule

// File: rtl/flash_rst_ctrl.sv
module flash_rst_ctrl #(
  parameter int MIN_PULSE = 3,
  parameter int RDY_IDLE  = 2,
  parameter int RDY_BUSY  = 10,
  parameter int RECOVER   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_rst_ni,
  input  logic busy_i,
  output logic rdy_o,
  output logic oe_en_o,
  output logic abort_o,
  output logic cmd_en_o,
  output logic sm_rst_o
);
  import frc_pkg::*;

  localparam int TMAX = (RDY_BUSY > RDY_IDLE) ?
                        ((RDY_BUSY > RECOVER) ? RDY_BUSY : RECOVER) :
                        ((RDY_IDLE > RECOVER) ? RDY_IDLE : RECOVER);
  localparam int TW   = $clog2(TMAX + 1);

  logic    hit, qual_q, was_busy_q;
  logic    rdy_done, rec_done, exit_rst, in_rst;
  logic [TW-1:0] rdy_limit;
  phase_e  phase;

  frc_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_ni  (dev_rst_ni),
    .hold_i  (qual_q),
    .hit_o   (hit),
    .abort_o (abort_o)
  );

  assign rdy_limit = was_busy_q ? TW'(RDY_BUSY) : TW'(RDY_IDLE);

  // ready time runs from the qualifying edge
  frc_sat_timer #(.W(TW)) u_rdy_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!qual_q),
    .en_i    (qual_q),
    .limit_i (rdy_limit),
    .done_o  (rdy_done)
  );

  // recovery restarts on every low edge of the pin
  frc_sat_timer #(.W(TW)) u_rec_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!qual_q || !dev_rst_ni),
    .en_i    (1'b1),
    .limit_i (TW'(RECOVER)),
    .done_o  (rec_done)
  );

  assign exit_rst = qual_q && dev_rst_ni && rdy_done && rec_done;
  assign in_rst   = qual_q && !exit_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q     <= 1'b0;
      was_busy_q <= 1'b0;
    end else begin
      if (hit)           qual_q <= 1'b1;
      else if (exit_rst) qual_q <= 1'b0;
      if (hit) was_busy_q <= busy_i;
    end
  end

  always_comb begin
    if (in_rst)           phase = PH_RST;
    else if (!dev_rst_ni) phase = PH_LOW;
    else                  phase = PH_RUN;
  end

  assign oe_en_o  = (phase == PH_RUN);
  assign cmd_en_o = (phase == PH_RUN);
  assign sm_rst_o = (phase == PH_RST);
  assign rdy_o    = in_rst ? !(was_busy_q && !rdy_done) : !busy_i;

  assert_pin_low_gates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_rst_ni |-> (!oe_en_o && !cmd_en_o));
  assert_abort_enters_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> sm_rst_o);
  assert_ready_monotonic_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_rst_o && rdy_o) |=> (rdy_o || !sm_rst_o));
  assert_exit_after_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sm_rst_o) |-> (dev_rst_ni && $past(dev_rst_ni)));
  assert_no_reabort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sm_rst_o && !abort_o) |-> !hit);
endmodule

// File: tb/sim_flash_rst_ctrl.sv
module sim_flash_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_PULSE  = 3;
  localparam int RDY_IDLE   = 2;
  localparam int RDY_BUSY   = 10;
  localparam int RECOVER    = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dev_rst_ni = 1'b1;
  logic busy_i = 1'b0;
  logic rdy_o, oe_en_o, abort_o, cmd_en_o, sm_rst_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rst_ctrl #(
    .MIN_PULSE(MIN_PULSE), .RDY_IDLE(RDY_IDLE),
    .RDY_BUSY(RDY_BUSY), .RECOVER(RECOVER)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .dev_rst_ni(dev_rst_ni), .busy_i(busy_i),
    .rdy_o(rdy_o), .oe_en_o(oe_en_o), .abort_o(abort_o),
    .cmd_en_o(cmd_en_o), .sm_rst_o(sm_rst_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int k,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s cycle=%0d act=%0b exp=%0b", tag, what, k, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pin low at edges 1..n, busy b until qualification, then flipped
  task automatic run_case(input int n, input logic b);
    bit qual;
    int lr, c, last;
    qual = (n >= MIN_PULSE);
    lr   = b ? RDY_BUSY : RDY_IDLE;
    c    = (n + RECOVER > MIN_PULSE + lr) ? n + RECOVER : MIN_PULSE + lr;
    last = qual ? c + 2 : n + 2;
    @(negedge clk);
    busy_i = b;
    dev_rst_ni = 1'b0;
    for (int k = 1; k <= last; k++) begin
      logic low, inr, bnow, e_oe, e_rdy;
      string t_oe, t_rdy;
      @(posedge clk);
      #1;
      low  = (k <= n);
      inr  = qual && k >= MIN_PULSE && k < c;
      bnow = (qual && k > MIN_PULSE) ? ~b : b;
      e_oe = !low && !inr;
      e_rdy = inr ? !(b && k < MIN_PULSE + lr) : !bnow;
      t_oe = low ? "R2" : (qual ? "R8" : "R3");
      if (inr) t_rdy = (k > MIN_PULSE) ? "R10" : (b ? "R6" : "R7");
      else     t_rdy = qual ? "R10" : "R3";
      if (inr && b && k < MIN_PULSE + lr) t_rdy = "R6";
      chk(t_oe, "oe_en_o", k, oe_en_o, e_oe);
      chk(t_oe, "cmd_en_o", k, cmd_en_o, e_oe);
      chk(qual ? "R4" : "R3", "abort_o", k, abort_o, qual && k == MIN_PULSE);
      chk(qual ? "R5" : "R3", "sm_rst_o", k, sm_rst_o, inr);
      chk(t_rdy, "rdy_o", k, rdy_o, e_rdy);
      @(negedge clk);
      if (k >= n) dev_rst_ni = 1'b1;
      if (qual && k == MIN_PULSE) busy_i = ~b;
    end
    busy_i = 1'b0;
    dev_rst_ni = 1'b1;
    idle(3);
  endtask

  // R9: low 1..4, high 5..6, low 7, high from 8; idle engine
  task automatic run_relow();
    int c;
    c = 7 + RECOVER;
    @(negedge clk);
    busy_i = 1'b0;
    dev_rst_ni = 1'b0;
    for (int k = 1; k <= c + 2; k++) begin
      logic low, inr;
      @(posedge clk);
      #1;
      low = (k <= 4) || (k == 7);
      inr = (k >= MIN_PULSE) && (k < c);
      chk("R9", "oe_en_o", k, oe_en_o, !low && !inr);
      chk("R9", "abort_o", k, abort_o, k == MIN_PULSE);
      chk("R9", "sm_rst_o", k, sm_rst_o, inr);
      chk("R7", "rdy_o", k, rdy_o, 1'b1);
      @(negedge clk);
      dev_rst_ni = !((k + 1 <= 4) || (k + 1 == 7));
    end
    dev_rst_ni = 1'b1;
    idle(3);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "rdy_o", 0, rdy_o, 1'b1);
    chk("R1", "oe_en_o", 0, oe_en_o, 1'b1);
    chk("R1", "cmd_en_o", 0, cmd_en_o, 1'b1);
    chk("R1", "abort_o", 0, abort_o, 1'b0);
    chk("R1", "sm_rst_o", 0, sm_rst_o, 1'b0);
    for (int b = 0; b < 2; b++)
      for (int n = 1; n <= MIN_PULSE + RDY_BUSY + 2; n++)
        run_case(n, logic'(b));
    run_relow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule